// File: doc/BRIEF.md
# Compare-Match Interval Timer

This block holds a parameterised number of interval timer channels behind a simple register port. Each channel has three registers: an up-counter, a constant to compare against, and a control/status word. A start register shared by all channels holds one run bit per channel. When a counting channel reaches its constant, the next count clears the counter to zero and sets a match flag. If its interrupt enable bit is set, the channel's interrupt line goes high and stays high until software clears the flag. The result is a periodic event every (constant + 1) counts. Each count step is a prescaled tick: the input clock divided by 8, 32, 128 or 512, picked by a control field.

The block is built either as a wide variant (32-bit counters, registers spaced 4 bytes apart) or as a narrow variant (16-bit counters, registers spaced 2 bytes apart). A parameter selects the variant.

Each channel is driven by a two-state machine:
- CH_STOPPED: the counter holds its value and the prescaler is held at zero. It goes to CH_COUNTING when the channel's run bit is 1.
- CH_COUNTING: the prescaler advances, and the counter steps on each tick. It goes back to CH_STOPPED when the run bit is 0.

Top module: `cmt_timer`

## Requirements
- R1: After reset, every counter reads 0, every constant reads all ones (0xFFFFFFFF wide, 0xFFFF narrow), every control word reads 0, the start register reads 0 and every interrupt is low.
- R2: Address map:
  - Register spacing STEP is 4 bytes (wide) or 2 bytes (narrow).
  - The start register is at byte 0.
  - Channel k starts at byte (k+1)*4*STEP. Control, counter and constant sit at index 0, 1 and 2 within the channel, each index multiplied by STEP.
  - A read returns its data on bus_rdata one cycle after the bus_rd cycle, zero-extended.
  - Counter and constant registers take the low 32 (wide) or 16 (narrow) bits of a write. Control and start take 16 bits.
  - An access whose address is not a multiple of STEP is ignored.
- R3: Bit k of the start register runs channel k. A stopped channel keeps its counter while other channels count and signal.
- R4: The first count lands 1+D clock cycles after the edge that writes the run bit, where D is the prescale divisor. Later counts follow every D cycles.
- R5: On a count with the counter equal to the constant, the counter becomes 0 and the match flag sets. The flag therefore repeats every (constant+1)*D cycles.
- R6: Control bits [1:0] pick D: 0 gives 8, 1 gives 32, 2 gives 128, 3 gives 512.
- R7: Flag positions:
  - The match flag is control bit 15 (wide) or bit 7 (narrow).
  - In the wide variant, bit 14 is a wrap flag. It is set when a count takes the counter from all ones to 0 with no match.
- R8: Writing 0 to a flag bit clears it and writing 1 leaves it unchanged. The other control bits (13:0 wide, 6:0 narrow) read back as written.
- R9: irq[k] is high exactly when channel k's match flag and its enable bit are both set. The enable bit is bit 5 (wide) or bit 6 (narrow). The wrap flag never raises irq. Writing 0 to the control word drops irq.
- R10: A constant written while running is used at the very next compare. If the counter is already above the new constant, it runs on to full scale without a match.
- R11: A stopped counter holds its value. A counter write loads its value at once and replaces any count in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | NUM_CH | Per-channel interrupt request |

## Verification
The main function is tried with the following constants, and each one separates a different fault:
- Small constants with divide-by-8 separate the start latency from the steady period, because the first match and the second match are timed separately.
- A counter preloaded just below full scale separates the wrap flag from the match flag and confirms that wrapping raises no interrupt.
- A constant rewritten below the running count shows that the comparison uses the live constant. A second rewrite above the count then produces a match at an exact cycle.
- Divide-by-32 and divide-by-512 runs on the second channel and on the narrow variant tell the prescale selections apart. These runs also show that the channels are independent.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

    typedef enum logic {
        CH_STOPPED  = 1'b0,
        CH_COUNTING = 1'b1
    } ch_state_e;

    typedef enum logic [1:0] {
        RS_CTRL  = 2'd0,
        RS_COUNT = 2'd1,
        RS_CONST = 2'd2,
        RS_NONE  = 2'd3
    } reg_idx_e;

    localparam int PRE_W = 9;

    // Last prescaler value before a tick, for each divisor selection.
    function automatic logic [PRE_W-1:0] div_limit(input logic [1:0] sel);
        unique case (sel)
            2'd0:    return 9'd7;
            2'd1:    return 9'd31;
            2'd2:    return 9'd127;
            default: return 9'd511;
        endcase
    endfunction

endpackage

// File: rtl/cmt_prescale.sv
module cmt_prescale
    import cmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic [1:0] div_sel,
    output logic       tick
);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] limit;

    assign limit = div_limit(div_sel);

    // ">=" keeps the divider safe when the selection shrinks mid-count.
    assign tick = active && (pre_q >= limit);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (!active || tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
    import cmt_pkg::*;
#(
    parameter int CW   = 32,
    parameter bit WIDE = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          wr_ctrl,
    input  logic          wr_count,
    input  logic          wr_const,
    input  logic [31:0]   wdata,
    output logic [CW-1:0] count_q,
    output logic [CW-1:0] const_q,
    output logic [15:0]   ctrl_rd,
    output logic          match_q,
    output logic          irq
);

    localparam int MATCH_BIT = WIDE ? 15 : 7;
    localparam int CFG_W     = WIDE ? 14 : 7;
    localparam int IE_BIT    = WIDE ? 5 : 6;

    ch_state_e        state_q, state_d;
    logic             active;
    logic             tick;
    logic             count_en;
    logic             at_const;
    logic             at_full;
    logic             hit;
    logic             roll;
    logic [CFG_W-1:0] cfg_q;

    cmt_prescale u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (active),
        .div_sel (cfg_q[1:0]),
        .tick    (tick)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_STOPPED;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_STOPPED:  if (run)  state_d = CH_COUNTING;
            CH_COUNTING: if (!run) state_d = CH_STOPPED;
        endcase
    end

    // State outputs
    always_comb begin
        active = 1'b0;
        unique case (state_q)
            CH_STOPPED:  active = 1'b0;
            CH_COUNTING: active = 1'b1;
        endcase
        // A bus load of the counter wins over a count in the same cycle.
        count_en = active && run && tick && !wr_count;
    end

    assign at_const = (count_q == const_q);
    assign at_full  = &count_q;
    assign hit      = count_en && at_const;
    assign roll     = count_en && !at_const && at_full;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (wr_count) begin
            count_q <= wdata[CW-1:0];
        end else if (count_en) begin
            if (at_const || at_full) begin
                count_q <= '0;
            end else begin
                count_q <= count_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            const_q <= '1;
        end else if (wr_const) begin
            const_q <= wdata[CW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            match_q <= 1'b0;
        end else if (wr_ctrl) begin
            cfg_q   <= wdata[CFG_W-1:0];
            match_q <= (match_q & wdata[MATCH_BIT]) | hit;
        end else begin
            match_q <= match_q | hit;
        end
    end

    generate
        if (WIDE) begin : g_wrap
            logic wrap_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    wrap_q <= 1'b0;
                end else if (wr_ctrl) begin
                    wrap_q <= (wrap_q & wdata[14]) | roll;
                end else begin
                    wrap_q <= wrap_q | roll;
                end
            end
            assign ctrl_rd = {match_q, wrap_q, cfg_q};
        end else begin : g_nowrap
            assign ctrl_rd = {8'h00, match_q, cfg_q};
        end
    endgenerate

    assign irq = match_q & cfg_q[IE_BIT];

endmodule

// File: rtl/cmt_timer.sv
module cmt_timer
    import cmt_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter bit WIDE   = 1'b1,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] irq
);

    localparam int CW      = WIDE ? 32 : 16;
    localparam int STEP    = WIDE ? 4 : 2;
    localparam int SPAN    = 4 * STEP;
    localparam int STEP_LG = $clog2(STEP);
    localparam int SPAN_LG = $clog2(SPAN);
    localparam int PG_W    = ADDR_W - SPAN_LG;

    logic [PG_W-1:0]   page;
    logic [1:0]        idx;
    logic              aligned;
    logic              start_sel;
    logic [NUM_CH-1:0] run_q;
    logic [NUM_CH-1:0] cnt_wr_v;
    logic [NUM_CH-1:0] ctrl_wr_v;
    logic [NUM_CH-1:0] const_wr_v;
    logic [NUM_CH-1:0] match_v;
    logic [CW-1:0]     count_v [NUM_CH];
    logic [CW-1:0]     const_v [NUM_CH];
    logic [15:0]       ctrl_v  [NUM_CH];
    logic [31:0]       rd_mux;

    assign page      = bus_addr[ADDR_W-1:SPAN_LG];
    assign idx       = bus_addr[SPAN_LG-1:STEP_LG];
    assign aligned   = (bus_addr[STEP_LG-1:0] == '0);
    assign start_sel = aligned && (page == '0) && (idx == 2'd0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (bus_wr && start_sel) begin
            run_q <= bus_wdata[NUM_CH-1:0];
        end
    end

    generate
        for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
            logic ch_sel;
            assign ch_sel        = aligned && (page == PG_W'(k + 1));
            assign ctrl_wr_v[k]  = bus_wr && ch_sel && (idx == RS_CTRL);
            assign cnt_wr_v[k]   = bus_wr && ch_sel && (idx == RS_COUNT);
            assign const_wr_v[k] = bus_wr && ch_sel && (idx == RS_CONST);

            cmt_channel #(
                .CW   (CW),
                .WIDE (WIDE)
            ) u_ch (
                .clk      (clk),
                .rst_n    (rst_n),
                .run      (run_q[k]),
                .wr_ctrl  (ctrl_wr_v[k]),
                .wr_count (cnt_wr_v[k]),
                .wr_const (const_wr_v[k]),
                .wdata    (bus_wdata),
                .count_q  (count_v[k]),
                .const_q  (const_v[k]),
                .ctrl_rd  (ctrl_v[k]),
                .match_q  (match_v[k]),
                .irq      (irq[k])
            );
        end
    endgenerate

    always_comb begin
        rd_mux = '0;
        if (start_sel) begin
            rd_mux = 32'(run_q);
        end
        if (aligned) begin
            for (int k = 0; k < NUM_CH; k++) begin
                if (page == PG_W'(k + 1)) begin
                    unique case (reg_idx_e'(idx))
                        RS_CTRL:  rd_mux = 32'(ctrl_v[k]);
                        RS_COUNT: rd_mux = 32'(count_v[k]);
                        RS_CONST: rd_mux = 32'(const_v[k]);
                        default:  rd_mux = '0;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/cmt_timer_chk.sv
module cmt_timer_chk #(
    parameter int NUM_CH = 2,
    parameter int CW     = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] run_q,
    input logic [NUM_CH-1:0] cnt_wr,
    input logic [NUM_CH-1:0] ctrl_wr,
    input logic [NUM_CH-1:0] match_v,
    input logic [NUM_CH-1:0] irq,
    input logic [CW-1:0]     cnt_v [NUM_CH]
);

    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
            AST_IRQ_FROM_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
                irq[i] |-> match_v[i]); // R9

            AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
                (!run_q[i] && !cnt_wr[i]) |=> $stable(cnt_v[i])); // R11

            AST_STEP_OR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
                !cnt_wr[i] |=> ((cnt_v[i] == $past(cnt_v[i])) ||
                                (cnt_v[i] == $past(cnt_v[i]) + ONE) ||
                                (cnt_v[i] == '0))); // R4

            AST_MATCH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(match_v[i]) |-> (cnt_v[i] == '0)); // R5

            AST_FLAG_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(match_v[i]) |-> $past(ctrl_wr[i])); // R8
        end
    endgenerate

endmodule

bind cmt_timer cmt_timer_chk #(
    .NUM_CH (NUM_CH),
    .CW     (CW)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_q   (run_q),
    .cnt_wr  (cnt_wr_v),
    .ctrl_wr (ctrl_wr_v),
    .match_v (match_v),
    .irq     (irq),
    .cnt_v   (count_v)
);

// File: tb/cmt_timer_bench.sv
module cmt_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_wr = 1'b0, a_rd = 1'b0, b_wr = 1'b0, b_rd = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] a_rdata, b_rdata;
    logic [1:0]  a_irq, b_irq;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    bit done = 1'b0;

    int          due_q[$];
    logic [31:0] exp_q[$];
    string       tag_q[$];
    bit          dut_q[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cmt_timer #(.NUM_CH(2), .WIDE(1'b1), .ADDR_W(8)) u_cmt_timer (
        .clk(clk), .rst_n(rst_n), .bus_wr(a_wr), .bus_rd(a_rd), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(a_rdata), .irq(a_irq));

    cmt_timer #(.NUM_CH(2), .WIDE(1'b0), .ADDR_W(8)) u_cmt_timer_n (
        .clk(clk), .rst_n(rst_n), .bus_wr(b_wr), .bus_rd(b_rd), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(b_rdata), .irq(b_irq));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input bit nb, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d;
        if (nb) b_wr = 1'b1; else a_wr = 1'b1;
        @(negedge clk);
        a_wr = 1'b0; b_wr = 1'b0;
    endtask

    // Driver: issues a read and queues the expected value for the monitor.
    task automatic rd(input bit nb, input logic [7:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        addr = a;
        if (nb) b_rd = 1'b1; else a_rd = 1'b1;
        due_q.push_back(cyc + 1);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        dut_q.push_back(nb);
        @(negedge clk);
        a_rd = 1'b0; b_rd = 1'b0;
    endtask

    // Monitor: compares read data once the read edge has passed.
    initial begin
        forever begin
            @(negedge clk);
            while (due_q.size() > 0 && due_q[0] <= cyc) begin
                int   d;
                logic [31:0] e;
                string t;
                bit   nb;
                d  = due_q.pop_front();
                e  = exp_q.pop_front();
                t  = tag_q.pop_front();
                nb = dut_q.pop_front();
                check(t, nb ? b_rdata : a_rdata, e);
            end
        end
    end

    task automatic wait_irq(input bit nb, input int ch, input int limit, output int k);
        k = 0;
        while (k < limit) begin
            @(negedge clk);
            k++;
            if (nb ? b_irq[ch] : a_irq[ch]) break;
        end
    endtask

    initial begin
        int k;
        int t1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        check("R1 irq A", 32'(a_irq), 32'h0);
        rd(0, 8'h10, 32'h0, "R1 ctrl");
        rd(0, 8'h14, 32'h0, "R1 count");
        rd(0, 8'h18, 32'hFFFF_FFFF, "R1 const wide");
        rd(0, 8'h00, 32'h0, "R1 start");
        rd(1, 8'h0C, 32'h0000_FFFF, "R1 const narrow");

        // R4 R5 periodic match, divide-by-8, constant 4
        wr(0, 8'h18, 32'd4);
        wr(0, 8'h10, 32'h01A4);
        wr(0, 8'h00, 32'h1);
        wait_irq(0, 0, 200, k);
        check("R4 first match latency", 32'(k), 32'd41);
        t1 = cyc;
        rd(0, 8'h10, 32'h81A4, "R7 match flag bit15");
        wr(0, 8'h10, 32'h41A4);
        rd(0, 8'h10, 32'h01A4, "R8 write0 clears, write1 keeps");
        check("R9 irq low after clear", 32'(a_irq[0]), 32'h0);
        wait_irq(0, 0, 200, k);
        check("R5 period", 32'(cyc - t1), 32'd40);

        // R11 hold and load while stopped
        wr(0, 8'h00, 32'h0);
        wr(0, 8'h14, 32'h1234);
        repeat (40) @(negedge clk);
        rd(0, 8'h14, 32'h1234, "R11 hold after load");
        wr(0, 8'h10, 32'h01A4);

        // R7 wrap from full scale without match
        wr(0, 8'h14, 32'hFFFF_FFFE);
        wr(0, 8'h18, 32'd5);
        wr(0, 8'h00, 32'h1);
        repeat (25) @(negedge clk);
        wr(0, 8'h00, 32'h0);
        rd(0, 8'h14, 32'd1, "R7 count after wrap");
        rd(0, 8'h10, 32'h41A4, "R7 wrap flag bit14");
        check("R9 wrap raises no irq", 32'(a_irq[0]), 32'h0);

        // R10 constant moved below the count: no match
        wr(0, 8'h10, 32'h81A4);
        wr(0, 8'h18, 32'd0);
        wr(0, 8'h00, 32'h1);
        repeat (100) @(negedge clk);
        wr(0, 8'h00, 32'h0);
        rd(0, 8'h14, 32'd13, "R10 count ran past constant");
        rd(0, 8'h10, 32'h01A4, "R10 no match below count");
        wr(0, 8'h18, 32'd15);
        wr(0, 8'h00, 32'h1);
        wait_irq(0, 0, 200, k);
        check("R10 new constant used", 32'(k), 32'd25);

        // R9 enable gating
        rd(0, 8'h10, 32'h81A4, "R9 flag set");
        wr(0, 8'h10, 32'h8184);
        check("R9 irq needs enable", 32'(a_irq[0]), 32'h0);
        rd(0, 8'h10, 32'h8184, "R8 fields stored");
        wr(0, 8'h10, 32'h0);
        rd(0, 8'h10, 32'h0, "R9 zero write");
        check("R9 irq low after zero", 32'(a_irq[0]), 32'h0);

        // R3 channel independence
        wr(0, 8'h00, 32'h0);
        wr(0, 8'h14, 32'h77);
        wr(0, 8'h28, 32'd2);
        wr(0, 8'h20, 32'h01A4);
        wr(0, 8'h00, 32'h2);
        wait_irq(0, 1, 200, k);
        check("R3 ch1 match", 32'(k), 32'd25);
        check("R3 irq vector", 32'(a_irq), 32'h2);
        rd(0, 8'h14, 32'h77, "R3 ch0 held");
        rd(0, 8'h00, 32'h2, "R2 start readback");

        // R6 divide-by-32
        wr(0, 8'h00, 32'h0);
        wr(0, 8'h24, 32'h0);
        wr(0, 8'h20, 32'h01A5);
        wr(0, 8'h00, 32'h2);
        wait_irq(0, 1, 400, k);
        check("R6 divide 32", 32'(k), 32'd97);

        // Narrow variant
        wr(1, 8'h0A, 32'h0001_2345);
        rd(1, 8'h0A, 32'h2345, "R2 narrow width");
        wr(1, 8'h0A, 32'h0);
        wr(1, 8'h0C, 32'd1);
        wr(1, 8'h0D, 32'h55);
        rd(1, 8'h0C, 32'd1, "R2 misaligned ignored");
        wr(1, 8'h08, 32'h43);
        wr(1, 8'h00, 32'h1);
        wait_irq(1, 0, 2000, k);
        check("R6 divide 512", 32'(k), 32'd1025);
        rd(1, 8'h08, 32'hC3, "R7 narrow flag bit7");
        wr(1, 8'h08, 32'h43);
        rd(1, 8'h08, 32'h43, "R8 narrow clear");
        check("R9 narrow irq low", 32'(b_irq[0]), 32'h0);
        wr(1, 8'h14, 32'd3);
        wr(1, 8'h10, 32'h40);
        wr(1, 8'h00, 32'h2);
        wait_irq(1, 1, 200, k);
        check("R6 divide 8 narrow", 32'(k), 32'd33);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule